// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block buffers 9-bit words between a write clock domain and a read clock domain whose frequencies and phases need not be related. Both pointers cross the domain boundary as Gray code through synchronizer chains. Each pointer carries one wrap bit beyond the address, so a full store can be told apart from an empty one.

While master reset is held, the block samples a mode input. That input picks one of two output disciplines, and the choice stays until the next master reset. In request mode, a word reaches the data output only when the reader asks for it. In fall-through mode, the oldest word moves to the output register without being asked, and the output register counts as one extra storage slot. Each mode gives the same two status pins its own meaning and polarity.

Two further controls exist. A partial reset empties the FIFO but keeps the latched mode. A retransmit strobe on the read side moves the read pointer back to location zero so that the data can be read a second time.

Top module: `dcfifo_modesel`

## Requirements
- R1: `mode_in` is captured only while `mrst_n` is low (0 = request mode, 1 = fall-through mode). Changing `mode_in` at any other time, including during a partial reset, has no effect on the status pin polarities.
- R2: In request mode, a written word appears on `rd_data` only after a read edge with `rd_req` high. Without such an edge, `rd_data` keeps its value.
- R3: In request mode, `rd_stat` is 0 when no unread word is stored and 1 otherwise. `wr_stat` is 0 when full and 1 otherwise. The FIFO holds exactly DEPTH words.
- R4: In fall-through mode, the first word written into an empty FIFO shows up on `rd_data` with `rd_stat` = 0, without any `rd_req`, within a few read clock edges. It then stays there until it is read.
- R5: In fall-through mode, `wr_stat` is 1 when full and 0 otherwise. The FIFO holds DEPTH+1 words.
- R6: Words come out in the order they were written, whether the writer and the reader run one after the other or at the same time.
- R7: A read request while the FIFO holds no word is ignored: `rd_data` and `rd_stat` do not change.
- R8: A write request while the FIFO is full is ignored: the word is never read out.
- R9: After master reset, `rd_data` is all zeros and both status pins show "empty, not full" in the polarity of the latched mode.
- R10: Partial reset empties the FIFO and keeps the latched mode. It leaves the content of `rd_data` untouched.
- R11: `rexmit_n` low at a read clock edge sets the read pointer to location zero. After that edge, `rd_stat` shows "no data" (0 in request mode, 1 in fall-through mode). The words written since the last reset are then read again from the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| mode_in | input | 1 | Mode select, sampled during master reset |
| wr_req | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | W | Write data |
| wr_stat | output | 1 | Full status: 0 = full (request mode), 1 = full (fall-through mode) |
| rd_req | input | 1 | Read request, sampled on `rd_clk` |
| rexmit_n | input | 1 | Retransmit strobe, active low, sampled on `rd_clk` |
| rd_data | output | W | Output register |
| rd_stat | output | 1 | Read status: 0 = empty (request mode), 0 = data valid (fall-through mode) |

## Verification
The bench fills the FIFO to its limit in each mode and checks the count. A wrong wrap bit or a missing output-register slot would show up as DEPTH-1, DEPTH or DEPTH+1 words where the other figure is due. It forces a write into a full FIFO and a read from an empty one. A design that fails to gate these would return a stray word, change `rd_data`, or fall through the pointer and replay stale data. It also runs retransmit and partial reset in both modes, and flips `mode_in` outside master reset. A design that resets the mode on partial reset, leaves the output flag unforced after a retransmit, or clears the output register on partial reset shows the wrong pin polarity or the wrong data.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // Output discipline latched during master reset
   typedef enum logic {
      FIFO_MODE_REQ  = 1'b0,
      FIFO_MODE_FALL = 1'b1
   } fifo_mode_e;

   // Fewest synchronizer stages accepted by the block
   localparam int unsigned DCF_MIN_SYNC = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int unsigned W     = 9,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int unsigned AW   = 4,
   parameter int unsigned SYNC = 2,
   localparam int unsigned PW  = AW + 1
) (
   input  logic          wr_clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_in,
   input  logic          wr_req,
   input  logic [PW-1:0] rgray_async,
   output logic [PW-1:0] wgray,
   output logic [AW-1:0] waddr,
   output logic          push,
   output logic          wr_stat,
   output logic          wrst_n,
   output fifo_mode_e    mode_w,
   output logic          full_w,
   output logic [PW-1:0] wptr_bin
);
   logic [SYNC-1:0] mr_sh;
   logic [SYNC-1:0] ar_sh;
   logic            wmr_n;
   logic            all_n;
   logic [PW-1:0]   rq;
   logic [PW-1:0]   rq_full;
   logic [PW-1:0]   wptr_nxt;
   logic [PW-1:0]   wgray_nxt;

   assign all_n = mrst_n & prst_n;

   // master reset: async assert, sync release (drives mode capture)
   always_ff @(posedge wr_clk or negedge mrst_n) begin
      if (!mrst_n) mr_sh <= '0;
      else         mr_sh <= {mr_sh[SYNC-2:0], 1'b1};
   end
   assign wmr_n = mr_sh[SYNC-1];

   // either reset clears the pointer state
   always_ff @(posedge wr_clk or negedge all_n) begin
      if (!all_n) ar_sh <= '0;
      else        ar_sh <= {ar_sh[SYNC-2:0], 1'b1};
   end
   assign wrst_n = ar_sh[SYNC-1];

   // mode follows the pin only while master reset holds this domain
   always_ff @(posedge wr_clk) begin
      if (!wmr_n) mode_w <= fifo_mode_e'(mode_in);
   end

   dcf_sync #(.W(PW), .STAGES(SYNC)) u_rsync (
      .clk   (wr_clk),
      .rst_n (wrst_n),
      .d     (rgray_async),
      .q     (rq)
   );

   assign push      = wr_req & ~full_w;
   assign wptr_nxt  = wptr_bin + PW'(push);
   assign wgray_nxt = wptr_nxt ^ (wptr_nxt >> 1);
   assign rq_full   = {~rq[PW-1:PW-2], rq[PW-3:0]};

   always_ff @(posedge wr_clk or negedge wrst_n) begin
      if (!wrst_n) begin
         wptr_bin <= '0;
         wgray    <= '0;
         full_w   <= 1'b0;
      end else begin
         wptr_bin <= wptr_nxt;
         wgray    <= wgray_nxt;
         full_w   <= (wgray_nxt == rq_full);
      end
   end

   assign waddr   = wptr_bin[AW-1:0];
   assign wr_stat = (mode_w == FIFO_MODE_FALL) ? full_w : ~full_w;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
   import dcf_pkg::*;
#(
   parameter int unsigned W    = 9,
   parameter int unsigned AW   = 4,
   parameter int unsigned SYNC = 2,
   localparam int unsigned PW  = AW + 1
) (
   input  logic          rd_clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_in,
   input  logic          rd_req,
   input  logic          rexmit_n,
   input  logic [PW-1:0] wgray_async,
   input  logic [W-1:0]  mem_rdata,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [W-1:0]  rd_data,
   output logic          rd_stat,
   output logic          rrst_n,
   output fifo_mode_e    mode_r,
   output logic          ov,
   output logic          empty_c,
   output logic [PW-1:0] rptr_bin
);
   logic [SYNC-1:0] mr_sh;
   logic [SYNC-1:0] ar_sh;
   logic            rmr_n;
   logic            all_n;
   logic [PW-1:0]   wq;
   logic [PW-1:0]   rptr_nxt;
   logic [PW-1:0]   rgray_nxt;
   logic            ld;
   logic            empty_q;
   logic            fall;

   assign all_n = mrst_n & prst_n;

   always_ff @(posedge rd_clk or negedge mrst_n) begin
      if (!mrst_n) mr_sh <= '0;
      else         mr_sh <= {mr_sh[SYNC-2:0], 1'b1};
   end
   assign rmr_n = mr_sh[SYNC-1];

   always_ff @(posedge rd_clk or negedge all_n) begin
      if (!all_n) ar_sh <= '0;
      else        ar_sh <= {ar_sh[SYNC-2:0], 1'b1};
   end
   assign rrst_n = ar_sh[SYNC-1];

   always_ff @(posedge rd_clk) begin
      if (!rmr_n) mode_r <= fifo_mode_e'(mode_in);
   end
   assign fall = (mode_r == FIFO_MODE_FALL);

   dcf_sync #(.W(PW), .STAGES(SYNC)) u_wsync (
      .clk   (rd_clk),
      .rst_n (rrst_n),
      .d     (wgray_async),
      .q     (wq)
   );

   // store empty as seen now; steers the load path
   assign empty_c = (rgray == wq);

   // load output register: on request, or to refill an idle fall-through slot
   assign ld        = rexmit_n & ~empty_c & (rd_req | (fall & ~ov));
   assign rptr_nxt  = !rexmit_n ? '0 : (rptr_bin + PW'(ld));
   assign rgray_nxt = rptr_nxt ^ (rptr_nxt >> 1);

   always_ff @(posedge rd_clk or negedge rrst_n) begin
      if (!rrst_n) begin
         rptr_bin <= '0;
         rgray    <= '0;
         empty_q  <= 1'b1;
         ov       <= 1'b0;
      end else begin
         rptr_bin <= rptr_nxt;
         rgray    <= rgray_nxt;
         empty_q  <= !rexmit_n ? 1'b1 : (rgray_nxt == wq);
         if (!rexmit_n)   ov <= 1'b0;
         else if (ld)     ov <= 1'b1;
         else if (rd_req) ov <= 1'b0;
      end
   end

   // output register cleared only by master reset
   always_ff @(posedge rd_clk or negedge rmr_n) begin
      if (!rmr_n)  rd_data <= '0;
      else if (ld) rd_data <= mem_rdata;
   end

   assign raddr   = rptr_bin[AW-1:0];
   assign rd_stat = fall ? ~ov : ~empty_q;
endmodule

// File: rtl/dcfifo_modesel.sv
module dcfifo_modesel
   import dcf_pkg::*;
#(
   parameter int unsigned W           = 9,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         wr_clk,
   input  logic         rd_clk,
   input  logic         mrst_n,
   input  logic         prst_n,
   input  logic         mode_in,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   output logic         wr_stat,
   input  logic         rd_req,
   input  logic         rexmit_n,
   output logic [W-1:0] rd_data,
   output logic         rd_stat
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dcfifo_modesel: DEPTH must be a power of two and at least 4");
   end
   if (SYNC_STAGES < DCF_MIN_SYNC) begin : g_bad_sync
      $error("dcfifo_modesel: SYNC_STAGES below minimum");
   end
   if (W < 1) begin : g_bad_width
      $error("dcfifo_modesel: W must be positive");
   end

   logic [PW-1:0] wgray;
   logic [PW-1:0] rgray;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic          push;
   logic [W-1:0]  mem_rdata;
   logic          wrst_n;
   logic          rrst_n;
   fifo_mode_e    mode_w;
   fifo_mode_e    mode_r;
   logic          full_w;
   logic          ov;
   logic          empty_c;
   logic [PW-1:0] wptr_bin;
   logic [PW-1:0] rptr_bin;

   dcf_wr_ctl #(.AW(AW), .SYNC(SYNC_STAGES)) u_wr (
      .wr_clk      (wr_clk),
      .mrst_n      (mrst_n),
      .prst_n      (prst_n),
      .mode_in     (mode_in),
      .wr_req      (wr_req),
      .rgray_async (rgray),
      .wgray       (wgray),
      .waddr       (waddr),
      .push        (push),
      .wr_stat     (wr_stat),
      .wrst_n      (wrst_n),
      .mode_w      (mode_w),
      .full_w      (full_w),
      .wptr_bin    (wptr_bin)
   );

   dcf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
      .wr_clk (wr_clk),
      .we     (push),
      .waddr  (waddr),
      .wdata  (wr_data),
      .raddr  (raddr),
      .rdata  (mem_rdata)
   );

   dcf_rd_ctl #(.W(W), .AW(AW), .SYNC(SYNC_STAGES)) u_rd (
      .rd_clk      (rd_clk),
      .mrst_n      (mrst_n),
      .prst_n      (prst_n),
      .mode_in     (mode_in),
      .rd_req      (rd_req),
      .rexmit_n    (rexmit_n),
      .wgray_async (wgray),
      .mem_rdata   (mem_rdata),
      .raddr       (raddr),
      .rgray       (rgray),
      .rd_data     (rd_data),
      .rd_stat     (rd_stat),
      .rrst_n      (rrst_n),
      .mode_r      (mode_r),
      .ov          (ov),
      .empty_c     (empty_c),
      .rptr_bin    (rptr_bin)
   );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk
   import dcf_pkg::*;
#(
   parameter int unsigned W  = 9,
   parameter int unsigned PW = 5
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          wrst_n,
   input logic          rrst_n,
   input logic          wr_req,
   input logic          full_w,
   input logic [PW-1:0] wptr_bin,
   input fifo_mode_e    mode_r,
   input logic          ov,
   input logic          empty_c,
   input logic          rd_req,
   input logic          rexmit_n,
   input logic [PW-1:0] rptr_bin,
   input logic [W-1:0]  rd_data,
   input logic          rd_stat
);
   // R8
   full_block_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
      (wr_req && full_w) |=> $stable(wptr_bin));

   // R7
   empty_read_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
      (rd_req && empty_c && rexmit_n && mode_r == FIFO_MODE_REQ) |=> $stable(rd_data));

   // R11
   rexmit_ptr_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
      (!rexmit_n) |=> (rptr_bin == '0));

   // R11
   rexmit_flag_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
      (!rexmit_n) |=> (rd_stat == logic'(mode_r)));

   // R4
   fall_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
      (mode_r == FIFO_MODE_FALL && ov && !rd_req && rexmit_n) |=> (ov && $stable(rd_data)));
endmodule

bind dcfifo_modesel dcf_chk #(.W(W), .PW(PW)) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .wrst_n   (wrst_n),
   .rrst_n   (rrst_n),
   .wr_req   (wr_req),
   .full_w   (full_w),
   .wptr_bin (wptr_bin),
   .mode_r   (mode_r),
   .ov       (ov),
   .empty_c  (empty_c),
   .rd_req   (rd_req),
   .rexmit_n (rexmit_n),
   .rptr_bin (rptr_bin),
   .rd_data  (rd_data),
   .rd_stat  (rd_stat)
);

// File: tb/tb_dcfifo_modesel.sv
module tb_dcfifo_modesel;
   localparam int W     = 9;
   localparam int DEPTH = 16;

   logic         wr_clk = 1'b0;
   logic         rd_clk = 1'b0;
   logic         mrst_n = 1'b0;
   logic         prst_n = 1'b1;
   logic         mode_in = 1'b0;
   logic         wr_req = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_stat;
   logic         rd_req = 1'b0;
   logic         rexmit_n = 1'b1;
   logic [W-1:0] rd_data;
   logic         rd_stat;

   int           checks = 0;
   int           fails  = 0;
   bit           cur_mode = 1'b0;
   logic [W-1:0] q [$];

   dcfifo_modesel #(.W(W), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
      .wr_clk   (wr_clk),
      .rd_clk   (rd_clk),
      .mrst_n   (mrst_n),
      .prst_n   (prst_n),
      .mode_in  (mode_in),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .wr_stat  (wr_stat),
      .rd_req   (rd_req),
      .rexmit_n (rexmit_n),
      .rd_data  (rd_data),
      .rd_stat  (rd_stat)
   );

   // 250 MHz on both sides, read clock offset by 1 ns
   always #2 wr_clk = ~wr_clk;
   initial begin
      #1;
      forever #2 rd_clk = ~rd_clk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit has_space();
      return cur_mode ? (wr_stat == 1'b0) : (wr_stat == 1'b1);
   endfunction

   task automatic do_mrst(input bit m);
      cur_mode = m;
      mode_in  = m;
      mrst_n   = 1'b0;
      repeat (4) @(negedge wr_clk);
      mrst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
      mode_in = ~m;           // later changes must not matter (R1)
      repeat (6) @(negedge rd_clk);
      q.delete();
   endtask

   task automatic do_prst();
      mode_in = ~cur_mode;    // opposite level during partial reset (R1)
      prst_n  = 1'b0;
      repeat (4) @(negedge wr_clk);
      prst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
      q.delete();
   endtask

   // driver: writes when the status pin shows room, records expected word
   task automatic wr_word(input logic [W-1:0] v, output bit acc);
      @(negedge wr_clk);
      if (has_space()) begin
         wr_req  = 1'b1;
         wr_data = v;
         q.push_back(v);
         acc = 1'b1;
      end else begin
         wr_req = 1'b0;
         acc    = 1'b0;
      end
   endtask

   task automatic wr_idle();
      @(negedge wr_clk);
      wr_req = 1'b0;
   endtask

   task automatic wr_force(input logic [W-1:0] v);
      @(negedge wr_clk);
      wr_req  = 1'b1;
      wr_data = v;
      @(negedge wr_clk);
      wr_req = 1'b0;
   endtask

   // monitor: takes one word if available and compares with the queue head
   task automatic rd_word(input string req, output bit got);
      logic [W-1:0] e;
      got = 1'b0;
      @(negedge rd_clk);
      if (!cur_mode) begin
         if (rd_stat == 1'b1) begin
            rd_req = 1'b1;
            @(negedge rd_clk);
            rd_req = 1'b0;
            got = 1'b1;
         end
      end else if (rd_stat == 1'b0) begin
         got = 1'b1;
      end
      if (got) begin
         if (q.size() == 0) chk(1'b0, req, int'(rd_data), 0);
         else begin
            e = q.pop_front();
            chk(rd_data == e, req, int'(rd_data), int'(e));
         end
         if (cur_mode) begin
            rd_req = 1'b1;
            @(negedge rd_clk);
            rd_req = 1'b0;
         end
      end
   endtask

   task automatic drain(input string req, output int n);
      int idle = 0;
      bit got;
      n = 0;
      for (int i = 0; i < 4000 && idle < 10; i++) begin
         rd_word(req, got);
         if (got) begin n++; idle = 0; end
         else idle++;
      end
   endtask

   task automatic fill(input logic [W-1:0] start, output int n);
      int rej = 0;
      bit acc;
      logic [W-1:0] v = start;
      n = 0;
      for (int i = 0; i < 8 * DEPTH && rej < 12; i++) begin
         wr_word(v, acc);
         if (acc) begin n++; v++; rej = 0; end
         else rej++;
      end
      wr_idle();
   endtask

   task automatic interleave(input logic [W-1:0] base, input string req);
      int got_n = 0;
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               bit acc = 1'b0;
               while (!acc) wr_word(base + W'(i), acc);
            end
            wr_idle();
         end
         begin
            bit got;
            for (int g = 0; g < 4000 && got_n < 40; g++) begin
               rd_word(req, got);
               if (got) got_n++;
            end
         end
      join
      chk(got_n == 40, req, got_n, 40);
   endtask

   task automatic rexmit_pulse();
      @(negedge rd_clk);
      rexmit_n = 1'b0;
      @(negedge rd_clk);
      rexmit_n = 1'b1;
   endtask

   initial begin
      bit           acc;
      int           n;
      logic [W-1:0] last;
      logic [W-1:0] saved [$];

      // ---------------- request mode ----------------
      do_mrst(1'b0);
      // R9 reset state
      chk(rd_data == '0, "R9 rd_data", int'(rd_data), 0);
      chk(rd_stat == 1'b0, "R9 rd_stat", rd_stat, 0);
      chk(wr_stat == 1'b1, "R1 wr_stat polarity", wr_stat, 1);

      for (int i = 0; i < 3; i++) wr_word(9'h010 + W'(i), acc);
      wr_idle();
      repeat (10) @(negedge rd_clk);
      // R2 no word without a request
      chk(rd_data == '0, "R2 held", int'(rd_data), 0);
      chk(rd_stat == 1'b1, "R3 not empty", rd_stat, 1);
      drain("R2 R6 ordered read", n);
      chk(n == 3, "R2 count", n, 3);
      chk(rd_stat == 1'b0, "R3 empty after drain", rd_stat, 0);

      // R7 read from empty
      last = rd_data;
      @(negedge rd_clk);
      rd_req = 1'b1;
      repeat (6) @(negedge rd_clk);
      rd_req = 1'b0;
      chk(rd_data == last, "R7 data kept", int'(rd_data), int'(last));
      chk(rd_stat == 1'b0, "R7 still empty", rd_stat, 0);

      // R3 capacity, R8 write when full
      fill(9'h040, n);
      chk(n == DEPTH, "R3 capacity", n, DEPTH);
      chk(wr_stat == 1'b0, "R3 full flag", wr_stat, 0);
      wr_force(9'h1AA);
      repeat (8) @(negedge rd_clk);
      drain("R8 no stray word", n);
      chk(n == DEPTH, "R8 drained count", n, DEPTH);

      interleave(9'h080, "R6 concurrent req");

      // R10 partial reset keeps mode and output register
      wr_word(9'h0C1, acc);
      wr_idle();
      repeat (8) @(negedge rd_clk);
      last = rd_data;
      do_prst();
      mode_in = 1'b0;
      chk(rd_stat == 1'b0, "R10 empty after prst", rd_stat, 0);
      chk(wr_stat == 1'b1, "R1 R10 mode kept", wr_stat, 1);
      chk(rd_data == last, "R10 rd_data kept", int'(rd_data), int'(last));

      // R11 retransmit in request mode
      for (int i = 0; i < 5; i++) wr_word(9'h100 + W'(i), acc);
      wr_idle();
      saved = q;
      repeat (10) @(negedge rd_clk);
      for (int i = 0; i < 2; i++) rd_word("R11 pre-read", acc);
      rexmit_pulse();
      chk(rd_stat == 1'b0, "R11 forced empty", rd_stat, 0);
      q = saved;
      drain("R11 reread", n);
      chk(n == 5, "R11 reread count", n, 5);

      // ---------------- fall-through mode ----------------
      do_mrst(1'b1);
      chk(rd_data == '0, "R9 rd_data ft", int'(rd_data), 0);
      chk(rd_stat == 1'b1, "R9 rd_stat ft", rd_stat, 1);
      chk(wr_stat == 1'b0, "R1 wr_stat ft", wr_stat, 0);

      // R4 fall-through of first word
      wr_word(9'h055, acc);
      wr_idle();
      n = 0;
      for (int i = 0; i < 10 && rd_stat != 1'b0; i++) begin
         @(negedge rd_clk);
         n++;
      end
      chk(rd_stat == 1'b0, "R4 valid", rd_stat, 0);
      chk(rd_data == 9'h055, "R4 data", int'(rd_data), 'h55);
      chk(n <= 6, "R4 latency", n, 6);
      repeat (5) @(negedge rd_clk);
      chk(rd_data == 9'h055 && rd_stat == 1'b0, "R4 held", int'(rd_data), 'h55);
      drain("R4 consume", n);

      // R7 fall-through read from empty
      last = rd_data;
      @(negedge rd_clk);
      rd_req = 1'b1;
      repeat (6) @(negedge rd_clk);
      rd_req = 1'b0;
      chk(rd_stat == 1'b1, "R7 ft no data", rd_stat, 1);
      chk(rd_data == last, "R7 ft data kept", int'(rd_data), int'(last));

      // R5 capacity, R8 write when full
      fill(9'h020, n);
      chk(n == DEPTH + 1, "R5 capacity", n, DEPTH + 1);
      chk(wr_stat == 1'b1, "R5 full flag", wr_stat, 1);
      wr_force(9'h1AA);
      drain("R8 ft no stray word", n);
      chk(n == DEPTH + 1, "R8 ft drained count", n, DEPTH + 1);

      interleave(9'h0A0, "R6 concurrent ft");

      // R10 partial reset in fall-through mode
      do_prst();
      mode_in = 1'b1;
      chk(wr_stat == 1'b0 && rd_stat == 1'b1, "R10 ft mode kept", {wr_stat, rd_stat}, 1);

      // R11 retransmit in fall-through mode
      for (int i = 0; i < 4; i++) wr_word(9'h130 + W'(i), acc);
      wr_idle();
      saved = q;
      repeat (10) @(negedge rd_clk);
      for (int i = 0; i < 2; i++) rd_word("R11 ft pre-read", acc);
      rexmit_pulse();
      chk(rd_stat == 1'b1, "R11 ft forced not ready", rd_stat, 1);
      q = saved;
      drain("R11 ft reread", n);
      chk(n == 4, "R11 ft reread count", n, 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule